// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port Register Bank

This block holds the control state for a bank of general-purpose I/O pins, arranged as two 8-bit ports. Each port has four registers: direction, output level, read polarity, and a captured input snapshot. A serial-bus slave front end issues reads and writes through a small synchronous register interface. That interface carries an address, a write strobe, a read strobe and a data byte. Read data appears on `reg_rdata` in the cycle after the read strobe. The strobes are single-cycle control pulses, so the interface has no back-pressure. Every strobe is accepted in the cycle it is presented.

Pin levels pass through a two-flop synchroniser. Reading a port's input register captures the synchronised levels into that port's snapshot. The value returned is the captured level, inverted bit by bit where the polarity register has a bit set. An active-low interrupt is raised whenever a pin configured as an input differs from its snapshot. The interrupt clears when the port is read again, or when the pin returns to its captured level. Pins configured as outputs are driven from the output register. They are still captured on reads, but they never raise the interrupt.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every direction register holds 0xFF (all pins inputs) and every output register holds 0xFF. Every polarity register holds 0x00. `pin_oe` is all zero. With all pins low, `irq_n` is 1.
- R2: Address bits [2:1] select the register kind: 0 input, 1 output, 2 polarity, 3 direction. Address bit 0 selects the port: port 0 is pins 7:0 and port 1 is pins 15:8.
- R3: A write to an output, polarity or direction address stores `reg_wdata`. A later read of that address returns the stored byte on `reg_rdata` one cycle after the read strobe.
- R4: Writes to the input addresses (0 and 1) change nothing that is visible.
- R5: A direction bit of 0 makes the pin an output: `pin_oe` is 1 and `pin_out` equals the output register bit. A direction bit of 1 makes `pin_oe` 0.
- R6: Reading an input address returns the synchronised pin levels XOR that port's polarity byte. The pins must be stable for at least two cycles before the read strobe.
- R7: Polarity inversion affects only input-register reads. It does not affect the readback of other registers or `pin_out`.
- R8: `irq_n` goes low within three clock edges after an input-configured pin changes away from its snapshot value.
- R9: Reading a port's input address loads that port's snapshot with the current synchronised levels, which clears the interrupt for that port. Reading the other port does not clear it.
- R10: `irq_n` returns to 1 without any read if the pins go back to their snapshot values.
- R11: Output-configured pins never drive `irq_n` low, but their levels are still returned by input reads.
- R12: The snapshot registers reset to 0x00, so pins that are high after reset raise the interrupt until they are read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register address (kind in [2:1], port in [0]) |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| pin_in | input | 16 | Pin levels, asynchronous |
| pin_oe | output | 16 | Per-pin driver enable |
| pin_out | output | 16 | Per-pin drive level |
| irq_n | output | 1 | Active-low change interrupt |

## Verification
The bench targets the snapshot behaviour. Pins that are high right after reset must raise the interrupt. A design that preloaded the snapshot would stay quiet there. A read of the wrong port must leave the interrupt asserted. A design that refreshed both snapshots on any read would clear it. Output-configured pins are toggled to show they stay silent on the interrupt but still appear in reads. A design that masked them from the capture, or failed to mask them from the compare, would show up there. Polarity is set on one port and then checked against raw readback and `pin_out`. This catches an inversion applied to the wrong path, and a write to an input address that was not discarded.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  typedef enum logic [1:0] {
    KIND_IN  = 2'd0,
    KIND_OUT = 2'd1,
    KIND_POL = 2'd2,
    KIND_DIR = 2'd3
  } reg_kind_e;

  localparam logic [7:0] DIR_RESET = 8'hFF;
  localparam logic [7:0] OUT_RESET = 8'hFF;
  localparam logic [7:0] POL_RESET = 8'h00;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_async;
      stage2_q <= stage1_q;
    end
  end

  assign d_sync = stage2_q;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_bank_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_sync,
  input  logic [W-1:0] wdata,
  input  logic         wr_dir,
  input  logic         wr_out,
  input  logic         wr_pol,
  input  logic         rd_in,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] out_q,
  output logic [W-1:0] pol_q,
  output logic [W-1:0] in_view,
  output logic         changed
);
  logic [W-1:0] snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= DIR_RESET[W-1:0];
      out_q  <= OUT_RESET[W-1:0];
      pol_q  <= POL_RESET[W-1:0];
      snap_q <= '0;
    end else begin
      if (wr_dir) dir_q <= wdata;
      if (wr_out) out_q <= wdata;
      if (wr_pol) pol_q <= wdata;
      if (rd_in)  snap_q <= lvl_sync;
    end
  end

  // Captured value as the reader sees it, after inversion.
  assign in_view = lvl_sync ^ pol_q;
  // Only input-direction pins take part in the compare.
  assign changed = |((lvl_sync ^ snap_q) & dir_q);

  p_dir_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> dir_q == $past(wdata));
  p_out_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out |=> out_q == $past(wdata));
  p_pol_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pol |=> pol_q == $past(wdata));
  p_snap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_in |=> $stable(snap_q));
  p_snap_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_in |=> snap_q == $past(lvl_sync));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int N_PORTS = 2,
  parameter int PORT_W  = 8,
  localparam int PSEL_W = $clog2(N_PORTS),
  localparam int ADDR_W = PSEL_W + 2,
  localparam int PINS   = N_PORTS * PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [PORT_W-1:0] reg_wdata,
  output logic [PORT_W-1:0] reg_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_oe,
  output logic [PINS-1:0]   pin_out,
  output logic              irq_n
);
  reg_kind_e         kind;
  logic [PSEL_W-1:0] psel;
  logic [PINS-1:0]   lvl_sync;
  logic [PORT_W-1:0] dir_a [N_PORTS];
  logic [PORT_W-1:0] out_a [N_PORTS];
  logic [PORT_W-1:0] pol_a [N_PORTS];
  logic [PORT_W-1:0] view_a[N_PORTS];
  logic [N_PORTS-1:0] chg;
  logic [PORT_W-1:0] rd_mux;
  logic              irq_q;

  assign kind = reg_kind_e'(reg_addr[ADDR_W-1 -: 2]);
  assign psel = reg_addr[PSEL_W-1:0];

  gpio_sync #(.W(PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pin_in), .d_sync(lvl_sync)
  );

  for (genvar i = 0; i < N_PORTS; i++) begin : g_port
    logic hit;
    assign hit = (psel == PSEL_W'(i));

    gpio_port #(.W(PORT_W)) u_port (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl_sync(lvl_sync[i*PORT_W +: PORT_W]),
      .wdata   (reg_wdata),
      .wr_dir  (reg_wr && hit && kind == KIND_DIR),
      .wr_out  (reg_wr && hit && kind == KIND_OUT),
      .wr_pol  (reg_wr && hit && kind == KIND_POL),
      .rd_in   (reg_rd && hit && kind == KIND_IN),
      .dir_q   (dir_a[i]),
      .out_q   (out_a[i]),
      .pol_q   (pol_a[i]),
      .in_view (view_a[i]),
      .changed (chg[i])
    );

    assign pin_oe [i*PORT_W +: PORT_W] = ~dir_a[i];
    assign pin_out[i*PORT_W +: PORT_W] = out_a[i];
  end

  always_comb begin
    case (kind)
      KIND_IN:  rd_mux = view_a[psel];
      KIND_OUT: rd_mux = out_a[psel];
      KIND_POL: rd_mux = pol_a[psel];
      default:  rd_mux = dir_a[psel];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
      irq_q     <= 1'b0;
    end else begin
      if (reg_rd) reg_rdata <= rd_mux;
      irq_q <= |chg;
    end
  end

  assign irq_n = ~irq_q;

  p_rdata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));
  p_irq_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|chg) |=> !irq_n);
endmodule

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_oe, pin_out;
  logic        irq_n;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_d = 0;

  always #10 clk = ~clk;

  gpio_bank u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .irq_n(irq_n)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    @(negedge clk); reg_addr = a; reg_rd = 1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: the read data is registered on the edge where reg_rd is seen.
  always @(posedge clk) rd_d <= reg_rd;
  always @(negedge clk) begin
    if (rd_d && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {8'h00, reg_rdata}, {8'h00, e});
    end
  end

  initial begin
    idle(3); rst_n = 1; idle(2);
    // R1 reset state, R2 address map, R12 snapshot resets to zero
    check("R1 pin_oe", pin_oe, 16'h0000);
    check("R1 irq_n", {15'd0, irq_n}, 16'd1);
    rd(3'd2, 8'hFF, "R1 out0"); rd(3'd3, 8'hFF, "R2 out1");
    rd(3'd4, 8'h00, "R1 pol0"); rd(3'd5, 8'h00, "R2 pol1");
    rd(3'd6, 8'hFF, "R1 dir0"); rd(3'd7, 8'hFF, "R2 dir1");
    rd(3'd0, 8'h00, "R12 in0");
    // R3/R5 port 0 to outputs
    wr(3'd2, 8'hA5); wr(3'd6, 8'h00);
    idle(1);
    check("R5 pin_oe", pin_oe, 16'h00FF);
    check("R5 pin_out", pin_out, 16'hFFA5);
    rd(3'd2, 8'hA5, "R3 out0");
    wr(3'd5, 8'h0F);
    rd(3'd5, 8'h0F, "R3 pol1");
    // R12: high pins after reset raise the interrupt
    pin_in[15:8] = 8'h3C; idle(4);
    check("R12 irq_n", {15'd0, irq_n}, 16'd0);
    rd(3'd1, 8'h33, "R6 in1 inverted");
    idle(2);
    check("R9 irq cleared", {15'd0, irq_n}, 16'd1);
    // R7 polarity leaves other paths alone
    rd(3'd3, 8'hFF, "R7 out1 raw");
    check("R7 pin_out", pin_out, 16'hFFA5);
    // R4 input writes ignored
    wr(3'd1, 8'hFF); wr(3'd0, 8'h55);
    rd(3'd1, 8'h33, "R4 in1"); rd(3'd0, 8'h00, "R4 in0");
    check("R4 pin_out", pin_out, 16'hFFA5);
    // R8 change raises interrupt; R9 other-port read does not clear
    pin_in[15:8] = 8'h3D; idle(4);
    check("R8 irq_n", {15'd0, irq_n}, 16'd0);
    rd(3'd0, 8'h00, "R9 in0"); idle(2);
    check("R9 other port", {15'd0, irq_n}, 16'd0);
    rd(3'd1, 8'h32, "R9 in1"); idle(2);
    check("R9 own port", {15'd0, irq_n}, 16'd1);
    // R10 return to snapshot clears by itself
    pin_in[15:8] = 8'h7D; idle(4);
    check("R10 set", {15'd0, irq_n}, 16'd0);
    pin_in[15:8] = 8'h3D; idle(4);
    check("R10 self clear", {15'd0, irq_n}, 16'd1);
    // R11 output pins masked from the compare, still captured
    pin_in[7:0] = 8'h81; idle(4);
    check("R11 no irq", {15'd0, irq_n}, 16'd1);
    rd(3'd0, 8'h81, "R11 in0 captured");
    wr(3'd6, 8'hFF); idle(4);
    check("R5 inputs undriven", pin_oe, 16'h0000);
    check("R11 irq after dir", {15'd0, irq_n}, 16'd1);
    idle(2);
    if (exp_q.size() != 0) check("R3 read queue drained", 16'(exp_q.size()), 16'd0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule